// File: doc/BRIEF.md
# Multi-Level Acquisition Sequencer

This block decides, sample by sample, which acquired samples are written to capture memory and when the capture is declared triggered and complete. It walks through a set of programmable levels. Each level owns two conditions built from eight recognizer flags: a storage condition that selects samples for storing, and an advance condition that, once it has been met a programmed number of times, moves the sequencer to a programmed destination level. Any level may name any level as its destination, itself included.

Software programs the levels through a small register port while the sequencer is stopped, and can read every setting back for self-test. Raising `run_i` restarts the walk at level 0. A level can be marked to raise the trigger flag when it advances, and a level marked terminal raises the done flag and freezes the walk when its advance condition is met.

The controller is a three-state machine. `ST_IDLE` is the stopped state. The start transition (IDLE to RUN) is taken when `run_i` is high. In `ST_RUN` each sample strobe is evaluated. The advance transition stays in RUN and changes the level. The finish transition (RUN to DONE) is taken when a terminal level's advance fires. The stop transitions (RUN to IDLE, DONE to IDLE) are taken when `run_i` falls. `ST_DONE` keeps the storage decisions going but makes no further level changes.

Top module: `acq_sequencer`

## Requirements
- R1: After reset the level is 0, `store_en_o`, `trig_o` and `done_o` are low, and every configuration field reads back as 0.
- R2: The register address is `{level[3:0], field[1:0]}`. Field 0 is the storage condition and field 1 is the advance condition, each laid out as AND mask in bits [7:0], OR mask in bits [15:8] and combine bit in bit 16. Field 2 holds the destination in bits [3:0], the trigger bit in bit 4 and the terminal bit in bit 5. Field 3 holds the occurrence count in bits [15:0]. Every field reads back as written, with unused bits at 0. A write to a level of 12 or higher is dropped, and such a level reads back as 0.
- R3: A write made while `run_i` is high changes nothing.
- R4: The start transition sets the level to 0, loads level 0's occurrence count, and clears `trig_o` and `done_o`.
- R5: For each condition, the AND term is true when every flag selected in the AND mask is high (it is true when the mask is empty). The OR term is true when any flag selected in the OR mask is high (it is false when the mask is empty). The condition is AND term AND OR term when the combine bit is 0, and AND term OR OR term when the combine bit is 1.
- R6: Only cycles with `sample_i` high count. Each counted sample on which the advance condition holds uses up one occurrence. The advance fires on the Nth such sample, and a count of 0 behaves as 1.
- R7: When the advance fires, the level becomes the destination, and the destination's occurrence count is loaded. A destination of 12 or higher goes to level 0.
- R8: `store_en_o` rises one clock after a sample on which the current level's storage condition holds. It uses the level in force before any advance on that same sample.
- R9: `trig_o` sets when a level with its trigger bit set fires its advance, and stays set until the next start.
- R10: When a terminal level fires, `done_o` sets and the level stays put. Storage decisions continue using that level.
- R11: While `run_i` is low, `store_en_o` is 0, and the level, `trig_o` and `done_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run control; high runs, a rise restarts at level 0 |
| sample_i | input | 1 | Sample strobe qualifying `flags_i` |
| flags_i | input | 8 | Recognizer flags for the current sample |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration address `{level, field}` |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for `cfg_addr_i` |
| store_en_o | output | 1 | Store the sample of the previous cycle |
| level_o | output | 4 | Current sequence level |
| trig_o | output | 1 | Trigger has occurred |
| done_o | output | 1 | Terminal level reached |

## Verification
The bench builds the block with its defaults: 12 levels, 8 flags, a 16-bit occurrence count and 32-bit data. These values keep the whole register space (levels 0 to 15) addressable. They let a single programmed path visit levels 0, 5, 3 and 11. They also leave the addresses of levels 12 to 15, and destination codes 12 to 15, free for out-of-range tests. The 16-bit count lets counts of 0, 1, 2 and 3 be tested one after another.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    localparam logic [1:0] FLD_STORE = 2'd0;
    localparam logic [1:0] FLD_ADV   = 2'd1;
    localparam logic [1:0] FLD_CTRL  = 2'd2;
    localparam logic [1:0] FLD_OCC   = 2'd3;

endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval #(
    parameter int NF = 8
) (
    input  logic [NF-1:0] flags_i,
    input  logic [NF-1:0] and_m_i,
    input  logic [NF-1:0] or_m_i,
    input  logic          op_i,
    output logic          hit_o
);
    logic and_term;
    logic or_term;

    always_comb begin
        and_term = &(flags_i | ~and_m_i);
        or_term  = |(flags_i & or_m_i);
        hit_o    = op_i ? (and_term | or_term) : (and_term & or_term);
    end

endmodule

// File: rtl/seq_level_regs.sv
module seq_level_regs
    import seq_pkg::*;
#(
    parameter int NL     = 12,
    parameter int NF     = 8,
    parameter int OCC_W  = 16,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 4,
    parameter int ADDR_W = LVL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              cfg_wr_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    input  logic [LVL_W-1:0]  cur_lvl_i,
    input  logic [LVL_W-1:0]  nxt_lvl_i,
    output logic [NF-1:0]     st_and_o,
    output logic [NF-1:0]     st_or_o,
    output logic              st_op_o,
    output logic [NF-1:0]     adv_and_o,
    output logic [NF-1:0]     adv_or_o,
    output logic              adv_op_o,
    output logic [LVL_W-1:0]  dest_o,
    output logic              trg_bit_o,
    output logic              fin_bit_o,
    output logic [OCC_W-1:0]  nxt_occ_o
);
    localparam int OP_BIT  = 2 * NF;
    localparam int TRG_BIT = LVL_W;
    localparam int FIN_BIT = LVL_W + 1;

    logic [NF-1:0]    st_and_q  [NL];
    logic [NF-1:0]    st_or_q   [NL];
    logic             st_op_q   [NL];
    logic [NF-1:0]    adv_and_q [NL];
    logic [NF-1:0]    adv_or_q  [NL];
    logic             adv_op_q  [NL];
    logic [LVL_W-1:0] dest_q    [NL];
    logic             trg_q     [NL];
    logic             fin_q     [NL];
    logic [OCC_W-1:0] occ_q     [NL];

    logic [LVL_W-1:0] a_lvl;
    logic [1:0]       a_fld;
    logic             a_ok;

    assign a_lvl = cfg_addr_i[ADDR_W-1:2];
    assign a_fld = cfg_addr_i[1:0];
    assign a_ok  = (int'(a_lvl) < NL);

    generate
        for (genvar g = 0; g < NL; g++) begin : g_lvl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_and_q[g]  <= '0;
                    st_or_q[g]   <= '0;
                    st_op_q[g]   <= 1'b0;
                    adv_and_q[g] <= '0;
                    adv_or_q[g]  <= '0;
                    adv_op_q[g]  <= 1'b0;
                    dest_q[g]    <= '0;
                    trg_q[g]     <= 1'b0;
                    fin_q[g]     <= 1'b0;
                    occ_q[g]     <= '0;
                end else if (cfg_wr_i && !run_i && (int'(a_lvl) == g)) begin
                    unique case (a_fld)
                        FLD_STORE: begin
                            st_and_q[g] <= cfg_wdata_i[NF-1:0];
                            st_or_q[g]  <= cfg_wdata_i[2*NF-1:NF];
                            st_op_q[g]  <= cfg_wdata_i[OP_BIT];
                        end
                        FLD_ADV: begin
                            adv_and_q[g] <= cfg_wdata_i[NF-1:0];
                            adv_or_q[g]  <= cfg_wdata_i[2*NF-1:NF];
                            adv_op_q[g]  <= cfg_wdata_i[OP_BIT];
                        end
                        FLD_CTRL: begin
                            dest_q[g] <= cfg_wdata_i[LVL_W-1:0];
                            trg_q[g]  <= cfg_wdata_i[TRG_BIT];
                            fin_q[g]  <= cfg_wdata_i[FIN_BIT];
                        end
                        FLD_OCC: occ_q[g] <= cfg_wdata_i[OCC_W-1:0];
                        default: ;
                    endcase
                end
            end

            // Configuration must not move while the sequencer runs.
            assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $past(run_i) |-> ($stable(occ_q[g]) && $stable(dest_q[g]) &&
                                  $stable(adv_and_q[g]) && $stable(st_and_q[g])));
        end
    endgenerate

    always_comb begin
        cfg_rdata_o = '0;
        if (a_ok) begin
            unique case (a_fld)
                FLD_STORE: begin
                    cfg_rdata_o[NF-1:0]    = st_and_q[a_lvl];
                    cfg_rdata_o[2*NF-1:NF] = st_or_q[a_lvl];
                    cfg_rdata_o[OP_BIT]    = st_op_q[a_lvl];
                end
                FLD_ADV: begin
                    cfg_rdata_o[NF-1:0]    = adv_and_q[a_lvl];
                    cfg_rdata_o[2*NF-1:NF] = adv_or_q[a_lvl];
                    cfg_rdata_o[OP_BIT]    = adv_op_q[a_lvl];
                end
                FLD_CTRL: begin
                    cfg_rdata_o[LVL_W-1:0] = dest_q[a_lvl];
                    cfg_rdata_o[TRG_BIT]   = trg_q[a_lvl];
                    cfg_rdata_o[FIN_BIT]   = fin_q[a_lvl];
                end
                FLD_OCC: cfg_rdata_o[OCC_W-1:0] = occ_q[a_lvl];
                default: ;
            endcase
        end
    end

    always_comb begin
        st_and_o  = st_and_q[cur_lvl_i];
        st_or_o   = st_or_q[cur_lvl_i];
        st_op_o   = st_op_q[cur_lvl_i];
        adv_and_o = adv_and_q[cur_lvl_i];
        adv_or_o  = adv_or_q[cur_lvl_i];
        adv_op_o  = adv_op_q[cur_lvl_i];
        dest_o    = dest_q[cur_lvl_i];
        trg_bit_o = trg_q[cur_lvl_i];
        fin_bit_o = fin_q[cur_lvl_i];
        nxt_occ_o = occ_q[nxt_lvl_i];
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int NL    = 12,
    parameter int OCC_W = 16,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             sample_i,
    input  logic             adv_hit_i,
    input  logic             st_hit_i,
    input  logic [LVL_W-1:0] dest_i,
    input  logic             trg_bit_i,
    input  logic             fin_bit_i,
    input  logic [OCC_W-1:0] nxt_occ_i,
    output logic [LVL_W-1:0] level_o,
    output logic [LVL_W-1:0] nxt_lvl_o,
    output logic             store_en_o,
    output logic             trig_o,
    output logic             done_o
);
    seq_state_t       state_q, state_d;
    logic [OCC_W-1:0] cnt_q;
    logic             start;
    logic             met;
    logic             fire;

    assign start = (state_q == ST_IDLE) && run_i;
    assign met   = run_i && sample_i && adv_hit_i;
    assign fire  = met && (cnt_q <= OCC_W'(1));

    always_comb begin
        if (start)
            nxt_lvl_o = '0;
        else if (int'(dest_i) < NL)
            nxt_lvl_o = dest_i;
        else
            nxt_lvl_o = '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_i) state_d = ST_RUN;
            ST_RUN: begin
                if (!run_i)
                    state_d = ST_IDLE;
                else if (fire && fin_bit_i)
                    state_d = ST_DONE;
            end
            ST_DONE: if (!run_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_o    <= '0;
            cnt_q      <= '0;
            store_en_o <= 1'b0;
            trig_o     <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    store_en_o <= 1'b0;
                    if (run_i) begin
                        level_o <= '0;
                        cnt_q   <= nxt_occ_i;
                        trig_o  <= 1'b0;
                        done_o  <= 1'b0;
                    end
                end
                ST_RUN: begin
                    store_en_o <= run_i && sample_i && st_hit_i;
                    if (fire) begin
                        if (trg_bit_i) trig_o <= 1'b1;
                        if (fin_bit_i) begin
                            done_o <= 1'b1;
                        end else begin
                            level_o <= nxt_lvl_o;
                            cnt_q   <= nxt_occ_i;
                        end
                    end else if (met) begin
                        cnt_q <= cnt_q - OCC_W'(1);
                    end
                end
                ST_DONE: store_en_o <= run_i && sample_i && st_hit_i;
                default: store_en_o <= 1'b0;
            endcase
        end
    end

    assert_level_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level_o) < NL);

    assert_store_needs_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        store_en_o |-> $past(sample_i && run_i));

    assert_trig_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && !start) |=> trig_o);

    assert_done_holds_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(done_o)) |-> $stable(level_o));

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (level_o == '0 && !trig_o && !done_o));

    assert_stopped_no_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !store_en_o);

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
    parameter int NUM_LEVELS = 12,
    parameter int NUM_FLAGS  = 8,
    parameter int OCC_W      = 16,
    parameter int DATA_W     = 32,
    parameter int LVL_W      = $clog2(NUM_LEVELS),
    parameter int ADDR_W     = LVL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              sample_i,
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  logic              cfg_wr_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    output logic              store_en_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              trig_o,
    output logic              done_o
);
    logic [NUM_FLAGS-1:0] st_and, st_or, adv_and, adv_or;
    logic                 st_op, adv_op, st_hit, adv_hit;
    logic [LVL_W-1:0]     dest, nxt_lvl;
    logic                 trg_bit, fin_bit;
    logic [OCC_W-1:0]     nxt_occ;

    seq_level_regs #(
        .NL(NUM_LEVELS), .NF(NUM_FLAGS), .OCC_W(OCC_W),
        .DATA_W(DATA_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .run_i(run_i),
        .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .cur_lvl_i(level_o), .nxt_lvl_i(nxt_lvl),
        .st_and_o(st_and), .st_or_o(st_or), .st_op_o(st_op),
        .adv_and_o(adv_and), .adv_or_o(adv_or), .adv_op_o(adv_op),
        .dest_o(dest), .trg_bit_o(trg_bit), .fin_bit_o(fin_bit),
        .nxt_occ_o(nxt_occ)
    );

    seq_cond_eval #(.NF(NUM_FLAGS)) i_store_cond (
        .flags_i(flags_i), .and_m_i(st_and), .or_m_i(st_or),
        .op_i(st_op), .hit_o(st_hit)
    );

    seq_cond_eval #(.NF(NUM_FLAGS)) i_adv_cond (
        .flags_i(flags_i), .and_m_i(adv_and), .or_m_i(adv_or),
        .op_i(adv_op), .hit_o(adv_hit)
    );

    seq_ctrl #(.NL(NUM_LEVELS), .OCC_W(OCC_W), .LVL_W(LVL_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .sample_i(sample_i),
        .adv_hit_i(adv_hit), .st_hit_i(st_hit), .dest_i(dest),
        .trg_bit_i(trg_bit), .fin_bit_i(fin_bit), .nxt_occ_i(nxt_occ),
        .level_o(level_o), .nxt_lvl_o(nxt_lvl), .store_en_o(store_en_o),
        .trig_o(trig_o), .done_o(done_o)
    );

endmodule

// File: tb/test_acq_sequencer.sv
module test_acq_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        sample_i = 1'b0;
    logic [7:0]  flags_i = '0;
    logic        cfg_wr_i = 1'b0;
    logic [5:0]  cfg_addr_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] cfg_rdata_o;
    logic        store_en_o;
    logic [3:0]  level_o;
    logic        trig_o;
    logic        done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // {flags, sample, exp_level, exp_store, exp_trig, exp_done}
    localparam logic [15:0] VEC [NV] = '{
        {8'h81, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0},
        {8'h80, 1'b1, 4'd0,  1'b1, 1'b0, 1'b0},
        {8'h01, 1'b1, 4'd0,  1'b0, 1'b0, 1'b0},
        {8'h81, 1'b1, 4'd5,  1'b1, 1'b0, 1'b0},
        {8'h00, 1'b1, 4'd5,  1'b1, 1'b0, 1'b0},
        {8'h04, 1'b0, 4'd5,  1'b0, 1'b0, 1'b0},
        {8'h04, 1'b1, 4'd3,  1'b1, 1'b1, 1'b0},
        {8'h31, 1'b1, 4'd11, 1'b0, 1'b1, 1'b0},
        {8'h48, 1'b1, 4'd11, 1'b1, 1'b1, 1'b0},
        {8'h08, 1'b1, 4'd11, 1'b0, 1'b1, 1'b0},
        {8'h40, 1'b1, 4'd11, 1'b1, 1'b1, 1'b0},
        {8'h08, 1'b1, 4'd11, 1'b0, 1'b1, 1'b1},
        {8'h48, 1'b1, 4'd11, 1'b1, 1'b1, 1'b1}
    };

    acq_sequencer i_acq_sequencer (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .sample_i(sample_i),
        .flags_i(flags_i), .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .store_en_o(store_en_o), .level_o(level_o), .trig_o(trig_o),
        .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int lvl, input int fld, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_i    = 1'b1;
        cfg_addr_i  = {lvl[3:0], fld[1:0]};
        cfg_wdata_i = d;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int lvl, input int fld, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr_i = {lvl[3:0], fld[1:0]};
        #1;
        chk(req, cfg_rdata_o, exp);
    endtask

    task automatic step(input logic [7:0] f, input logic s);
        @(negedge clk);
        flags_i  = f;
        sample_i = s;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic set_run(input logic r);
        @(negedge clk);
        run_i    = r;
        sample_i = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 level", 32'(level_o), 32'd0);
        chk("R1 store", 32'(store_en_o), 32'd0);
        chk("R1 trig", 32'(trig_o), 32'd0);
        chk("R1 done", 32'(done_o), 32'd0);
        rd_chk("R1 cfg", 4, 1, 32'h0);

        // Program the path 0 -> 5 -> 3 -> 11 (terminal)
        wr(0, 1, 32'h0001_0001); wr(0, 0, 32'h0001_0080); wr(0, 2, 32'h05); wr(0, 3, 32'd2);
        wr(5, 1, 32'h0000_0600); wr(5, 0, 32'h0001_0000); wr(5, 2, 32'h13); wr(5, 3, 32'd0);
        wr(3, 1, 32'h0000_0330); wr(3, 0, 32'h0000_0000); wr(3, 2, 32'h0B); wr(3, 3, 32'd1);
        wr(11, 1, 32'h0001_0008); wr(11, 0, 32'h0000_4000); wr(11, 2, 32'h20); wr(11, 3, 32'd3);

        // R2 readback and out-of-range level
        rd_chk("R2 adv", 0, 1, 32'h0001_0001);
        rd_chk("R2 store", 11, 0, 32'h0000_4000);
        rd_chk("R2 ctrl", 5, 2, 32'h13);
        rd_chk("R2 occ", 11, 3, 32'd3);
        wr(12, 3, 32'd5);
        rd_chk("R2 oor", 12, 3, 32'h0);

        // R4 start
        set_run(1'b1);
        chk("R4 level", 32'(level_o), 32'd0);
        chk("R4 trig", 32'(trig_o), 32'd0);

        // Vector walk: R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][15:8], VEC[i][7]);
            chk("R7 level", 32'(level_o), 32'(VEC[i][6:3]));
            chk("R8 store", 32'(store_en_o), 32'(VEC[i][2]));
            chk("R9 trig", 32'(trig_o), 32'(VEC[i][1]));
            chk("R10 done", 32'(done_o), 32'(VEC[i][0]));
        end

        // R11 stop: outputs hold, no store
        @(negedge clk);
        run_i = 1'b0; flags_i = 8'h48; sample_i = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R11 store", 32'(store_en_o), 32'd0);
        chk("R11 level", 32'(level_o), 32'd11);
        chk("R11 done", 32'(done_o), 32'd1);
        chk("R11 trig", 32'(trig_o), 32'd1);

        // R4 restart clears flags
        set_run(1'b1);
        chk("R4 relevel", 32'(level_o), 32'd0);
        chk("R4 redone", 32'(done_o), 32'd0);
        chk("R4 retrig", 32'(trig_o), 32'd0);

        // R3 write while running is dropped
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_addr_i = {4'd0, 2'd3}; cfg_wdata_i = 32'd7;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        set_run(1'b0);
        rd_chk("R3 occ", 0, 3, 32'd2);

        // R7 destination out of range goes to level 0
        wr(0, 2, 32'h01);
        wr(1, 1, 32'h0001_0001); wr(1, 2, 32'h0E); wr(1, 3, 32'd1);
        set_run(1'b1);
        step(8'h01, 1'b1);
        chk("R6 count", 32'(level_o), 32'd0);
        step(8'h01, 1'b1);
        chk("R7 to1", 32'(level_o), 32'd1);
        step(8'h01, 1'b1);
        chk("R7 oor dest", 32'(level_o), 32'd0);
        step(8'h01, 1'b1);
        chk("R6 reload", 32'(level_o), 32'd0);
        step(8'h01, 1'b1);
        chk("R6 again", 32'(level_o), 32'd1);
        set_run(1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule